// File: doc/BRIEF.md
# Isochronous IN Frame-Aligned Release Control

This block keeps the packet-ready state for a set of isochronous IN endpoints. It decides, for each IN token, whether the transmit path sends the stored packet or an empty (zero-length) packet. Software raises a ready strobe for an endpoint once its packet buffer is filled. One global update mode selects when such a packet may be sent. With the mode off, a ready packet goes out on the next IN token. With the mode on, the packet waits until the next Start-Of-Frame. Any token that arrives before then is answered with an empty packet.

Each endpoint holds two flags. `pending` means software has handed over a packet. `committed` means a Start-Of-Frame has been seen while that packet was pending. Sending a packet clears both flags. A bus reset or a software reset clears both flags on every endpoint. The packet memory and the serializer live outside this block. The block only issues a one-cycle decision pulse together with the endpoint number.

Top module: `iso_in_release`

## Requirements
- R1: After reset, `pending_o` and `committed_o` are all zero, and neither `send_pkt_o` nor `send_zlp_o` is high.
- R2: A ready strobe on bit e of `rdy_set_i` sets bit e of `pending_o` in the next cycle.
- R3: With `upd_en_i` low, a token for an endpoint whose pending bit is set gives `send_pkt_o`=1 and `tx_ep_o`=endpoint in the cycle after the token. That endpoint's pending and committed bits read 0 in the same cycle.
- R4: With `upd_en_i` high, a token for an endpoint that is pending but not committed gives `send_zlp_o`=1. The pending bit stays set.
- R5: A Start-Of-Frame sets the committed bit of every endpoint whose pending bit was already set. A later token for that endpoint gives `send_pkt_o`=1 and clears both of its bits.
- R6: If a ready strobe and a Start-Of-Frame arrive in the same cycle, the packet is not committed. It needs the following Start-Of-Frame.
- R7: A token for an endpoint with nothing eligible gives `send_zlp_o`=1 and `tx_ep_o`=endpoint in the next cycle. This is the underrun indication.
- R8: `upd_en_i` is a single bit that governs every endpoint. One Start-Of-Frame commits all pending endpoints together.
- R9: `bus_rst_i` or `soft_rst_i` clears every pending and committed bit in the next cycle. A token in that same cycle gets no response.
- R10: `send_pkt_o` and `send_zlp_o` pulse only in the cycle after a token that was not flushed, and exactly one of them pulses per such token.
- R11: A ready strobe that arrives in the cycle in which the same endpoint's packet is sent leaves the endpoint pending and uncommitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en_i | input | 1 | Global update mode: hold packets until the next Start-Of-Frame |
| bus_rst_i | input | 1 | Bus reset detected (flush) |
| soft_rst_i | input | 1 | Software reset (flush) |
| rdy_set_i | input | NUM_EP | Per-endpoint packet-ready strobe from software |
| sof_i | input | 1 | Start-Of-Frame strobe |
| tok_i | input | 1 | IN token strobe |
| tok_ep_i | input | EP_W | Endpoint addressed by the token |
| send_pkt_o | output | 1 | Pulse: transmit the stored packet (packet sent) |
| send_zlp_o | output | 1 | Pulse: transmit a zero-length packet (underrun) |
| tx_ep_o | output | EP_W | Endpoint of the current decision |
| pending_o | output | NUM_EP | Per-endpoint pending flags |
| committed_o | output | NUM_EP | Per-endpoint committed flags |

## Verification
A flag that is wrong inside the block shows up at the ports as the wrong decision on the very next token. A packet released before its frame appears as `send_pkt_o` where `send_zlp_o` was due. A packet that was lost appears as `send_zlp_o` where `send_pkt_o` was due. Both flags are also brought out directly. A missed set, commit or clear is therefore visible one cycle after the strobe that should have caused it, without waiting for a token. The sweep covers both modes on every endpoint, including the same-cycle ready and Start-Of-Frame case and the same-cycle send and ready case.

// File: rtl/iso_rel_pkg.sv
package iso_rel_pkg;
  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_DATA = 2'd1,
    RSP_ZLP  = 2'd2
  } rsp_e;
endpackage

// File: rtl/iso_ep_flags.sv
module iso_ep_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en,
  input  logic flush,
  input  logic rdy_set,
  input  logic sof,
  input  logic take,
  output logic pending,
  output logic committed,
  output logic eligible
);
  logic pend_nxt, comm_nxt, flag_en;

  always_comb begin
    pend_nxt = pending;
    comm_nxt = committed;
    if (flush) begin
      pend_nxt = 1'b0;
      comm_nxt = 1'b0;
    end else begin
      if (take) begin
        pend_nxt = 1'b0;
        comm_nxt = 1'b0;
      end else if (sof && pending) begin
        comm_nxt = 1'b1;
      end
      if (rdy_set) pend_nxt = 1'b1;
    end
  end

  assign flag_en  = flush | take | sof | rdy_set;
  assign eligible = committed | (pending & ~upd_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      committed <= 1'b0;
    end else if (flag_en) begin
      pending   <= pend_nxt;
      committed <= comm_nxt;
    end
  end

  AST_COMMIT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    committed |-> pending) else $error("committed without pending"); // R5
  AST_COMMIT_ONLY_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(committed) |-> ($past(sof) && $past(pending))) else $error("commit without prior pending SOF"); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!pending && !committed)) else $error("flush left state"); // R9
endmodule

// File: rtl/iso_tok_resp.sv
module iso_tok_resp
  import iso_rel_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              tok,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic [NUM_EP-1:0] eligible,
  output logic [NUM_EP-1:0] take,
  output logic              send_pkt,
  output logic              send_zlp,
  output logic [EP_W-1:0]   tx_ep
);
  rsp_e            rsp_q, rsp_nxt;
  logic [EP_W-1:0] ep_q;
  logic            hit, tok_live;

  assign tok_live = tok & ~flush;
  assign hit      = tok_live & (32'(tok_ep) < NUM_EP) & eligible[tok_ep];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_take
    assign take[i] = hit && (32'(tok_ep) == i);
  end

  always_comb begin
    rsp_nxt = RSP_NONE;
    if (tok_live) rsp_nxt = hit ? RSP_DATA : RSP_ZLP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= RSP_NONE;
      ep_q  <= '0;
    end else begin
      rsp_q <= rsp_nxt;
      if (tok_live) ep_q <= tok_ep;
    end
  end

  assign send_pkt = (rsp_q == RSP_DATA);
  assign send_zlp = (rsp_q == RSP_ZLP);
  assign tx_ep    = ep_q;

  AST_RESP_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (send_pkt || send_zlp) |-> ($past(tok) && !$past(flush))) else $error("response without token"); // R10
  AST_TOKEN_GETS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (tok && !flush) |=> (send_pkt || send_zlp)) else $error("token without response"); // R10
endmodule

// File: rtl/iso_in_release.sv
module iso_in_release
  import iso_rel_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en_i,
  input  logic              bus_rst_i,
  input  logic              soft_rst_i,
  input  logic [NUM_EP-1:0] rdy_set_i,
  input  logic              sof_i,
  input  logic              tok_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  output logic              send_pkt_o,
  output logic              send_zlp_o,
  output logic [EP_W-1:0]   tx_ep_o,
  output logic [NUM_EP-1:0] pending_o,
  output logic [NUM_EP-1:0] committed_o
);
  logic              flush;
  logic [NUM_EP-1:0] take, eligible;

  assign flush = bus_rst_i | soft_rst_i;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    iso_ep_flags i_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (upd_en_i),
      .flush     (flush),
      .rdy_set   (rdy_set_i[e]),
      .sof       (sof_i),
      .take      (take[e]),
      .pending   (pending_o[e]),
      .committed (committed_o[e]),
      .eligible  (eligible[e])
    );
  end

  iso_tok_resp #(.NUM_EP(NUM_EP)) i_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .tok      (tok_i),
    .tok_ep   (tok_ep_i),
    .eligible (eligible),
    .take     (take),
    .send_pkt (send_pkt_o),
    .send_zlp (send_zlp_o),
    .tx_ep    (tx_ep_o)
  );

  AST_SENT_UNCOMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    send_pkt_o |-> !committed_o[tx_ep_o]) else $error("sent endpoint still committed"); // R3
  AST_HOLD_UNTIL_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (send_pkt_o && $past(upd_en_i)) |-> !$past(pending_o[tx_ep_o]) || $past(committed_o[tx_ep_o]))
    else $error("packet released before frame"); // R4
endmodule

// File: tb/test_iso_in_release.sv
module test_iso_in_release;
  localparam int NUM_EP = 4;
  localparam int EP_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              upd_en_i = 1'b0, bus_rst_i = 1'b0, soft_rst_i = 1'b0;
  logic [NUM_EP-1:0] rdy_set_i = '0;
  logic              sof_i = 1'b0, tok_i = 1'b0;
  logic [EP_W-1:0]   tok_ep_i = '0;
  logic              send_pkt_o, send_zlp_o;
  logic [EP_W-1:0]   tx_ep_o;
  logic [NUM_EP-1:0] pending_o, committed_o;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  iso_in_release #(.NUM_EP(NUM_EP)) i_iso_in_release (
    .clk(clk), .rst_n(rst_n), .upd_en_i(upd_en_i), .bus_rst_i(bus_rst_i),
    .soft_rst_i(soft_rst_i), .rdy_set_i(rdy_set_i), .sof_i(sof_i), .tok_i(tok_i),
    .tok_ep_i(tok_ep_i), .send_pkt_o(send_pkt_o), .send_zlp_o(send_zlp_o),
    .tx_ep_o(tx_ep_o), .pending_o(pending_o), .committed_o(committed_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock edge, then strobes return to zero; outputs sampled at negedge
  task automatic tick();
    @(negedge clk);
    rdy_set_i = '0; sof_i = 1'b0; tok_i = 1'b0; bus_rst_i = 1'b0; soft_rst_i = 1'b0;
  endtask

  task automatic token(int ep);
    tok_i = 1'b1; tok_ep_i = EP_W'(ep); tick();
  endtask

  function automatic logic [31:0] rsp(logic p, logic z, int ep);
    return {28'd0, p, z, EP_W'(ep)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 flags", {pending_o, committed_o}, 0);
    chk("R1 resp", {send_pkt_o, send_zlp_o}, 0);
    for (int m = 0; m < 2; m++) begin
      upd_en_i = m[0];
      for (int e = 0; e < NUM_EP; e++) begin
        // ready then token
        rdy_set_i[e] = 1'b1; tick();
        chk("R2 pending set", pending_o, 1 << e);
        token(e);
        if (m == 0) begin
          chk("R3 send", rsp(send_pkt_o, send_zlp_o, tx_ep_o), rsp(1, 0, e));
          chk("R3 cleared", {pending_o, committed_o}, 0);
        end else begin
          chk("R4 held zlp", rsp(send_pkt_o, send_zlp_o, tx_ep_o), rsp(0, 1, e));
          chk("R4 still pending", pending_o, 1 << e);
          sof_i = 1'b1; tick();
          chk("R5 committed", committed_o, 1 << e);
          token(e);
          chk("R5 send", rsp(send_pkt_o, send_zlp_o, tx_ep_o), rsp(1, 0, e));
          chk("R5 cleared", {pending_o, committed_o}, 0);
          // ready and SOF together
          rdy_set_i[e] = 1'b1; sof_i = 1'b1; tick();
          chk("R6 not committed", {pending_o, committed_o}, (1 << e) << NUM_EP);
          token(e);
          chk("R6 zlp", rsp(send_pkt_o, send_zlp_o, tx_ep_o), rsp(0, 1, e));
          sof_i = 1'b1; tick();
          token(e);
          chk("R6 later send", rsp(send_pkt_o, send_zlp_o, tx_ep_o), rsp(1, 0, e));
        end
        // empty endpoint
        token(e);
        chk("R7 underrun", rsp(send_pkt_o, send_zlp_o, tx_ep_o), rsp(0, 1, e));
        tick();
        chk("R10 idle no resp", {send_pkt_o, send_zlp_o}, 0);
        // send with new ready in same cycle
        rdy_set_i[e] = 1'b1; tick();
        if (m == 1) begin sof_i = 1'b1; tick(); end
        rdy_set_i[e] = 1'b1; token(e);
        chk("R11 send", rsp(send_pkt_o, send_zlp_o, tx_ep_o), rsp(1, 0, e));
        chk("R11 repending", {pending_o, committed_o}, (1 << e) << NUM_EP);
        // all endpoints on one SOF, then flush
        rdy_set_i = '1; tick();
        sof_i = 1'b1; tick();
        chk("R8 all committed", committed_o, {NUM_EP{1'b1}});
        if (e % 2 == 0) bus_rst_i = 1'b1; else soft_rst_i = 1'b1;
        token(e);
        chk("R9 flushed", {pending_o, committed_o}, 0);
        chk("R9 no resp", {send_pkt_o, send_zlp_o}, 0);
        token(e);
        chk("R9 after flush zlp", rsp(send_pkt_o, send_zlp_o, tx_ep_o), rsp(0, 1, e));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule